// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects thirty-two level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Each line has its own enable mask. Software changes a mask only through a pair of word addresses, one that sets the bits given in the written data and one that clears them. No read-modify-write is needed, so two software agents can share a mask without racing. Both lines see the same raw level vector. One bit of a source can go to the normal line, the fast line, both, or neither.

A processor reads, for each line, the masked status (the sources that currently drive that line) and the raw level of all sources. Source 0 can also be raised and lowered by software through a second set/clear pair, which lets code post an interrupt to itself. Several controllers can be chained: the normal request of a secondary controller is wired into one source input of a primary controller (input 26 is the usual choice). The secondary's sources are then seen through the primary's mask and status.

The register bus is a plain synchronous write port with a combinational read port, addressed in 32-bit words. Both request lines come from flops, so they are glitch-free.

Top module: `intc_dual_lvl`

## Requirements
- R1: After reset, both enable masks and the software bit of source 0 are zero, `irq_o` and `fiq_o` are low, and reads of word offsets 2, 4 and 10 return zero.
- R2: The level vector is `src_i` with bit 0 ORed with the software bit. Reads of word offset 1 (normal bank) and word offset 9 (fast bank) both return the full level vector.
- R3: A write to offset 2 ORs `wdata` into the normal mask. A write to offset 10 ORs `wdata` into the fast mask. Reads of offset 2 and offset 10 return the current normal and fast mask.
- R4: A write to offset 3 clears in the normal mask every bit that is 1 in `wdata`. A write to offset 11 does the same to the fast mask. Other mask bits keep their value.
- R5: Offset 0 reads the level vector AND the normal mask. Offset 8 reads the level vector AND the fast mask.
- R6: A write to offset 4 sets the software bit, and a write to offset 5 clears it, but only when `wdata[0]` is 1. Otherwise the write has no effect. A read of offset 4 returns level bit 0 in bit 0, with zeros above it.
- R7: At each rising clock edge, `irq_o` takes the value "level AND normal mask is nonzero", and `fiq_o` takes the value "level AND fast mask is nonzero". Either output therefore follows a source change one clock later, and follows a mask write or software-bit write two edges after the write starts.
- R8: Reads of the clear-only offsets 3, 5 and 11, and of the unmapped offsets 6, 7, 12 to 15, return zero.
- R9: Writes to the status and raw offsets 0, 1, 8 and 9 change neither mask nor the software bit.
- R10: The two outputs are independent. A source enabled only in the fast mask raises `fiq_o` and leaves `irq_o` low, and the reverse holds for the normal mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, synchronous to `clk` |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| addr | input | 4 | Word offset for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The assertions assume that `src_i`, `wr_en`, `addr` and `wdata` are already synchronous to `clk`, so a sampled value is the settled one. They also assume that at most one register write occurs per cycle, which means a set and a clear of the same mask never coincide. The stimulus respects both. All inputs change only on the falling edge. Each write is a single strobe cycle, followed by an idle cycle before outputs and read data are sampled. Asynchronous sources are outside this contract and need synchronizers upstream.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned NSRC        = 32;
  localparam int unsigned AW          = 4;
  localparam int unsigned NOUT        = 2;
  localparam int unsigned BANK_STRIDE = 8;
  localparam int unsigned BANK_IRQ    = 0;
  localparam int unsigned BANK_FIQ    = 1;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_RAW  = 2'd1,
    SEL_ESET = 2'd2,
    SEL_ECLR = 2'd3
  } bank_sel_e;

  localparam logic [AW-1:0] OFS_SW_SET = AW'(4);
  localparam logic [AW-1:0] OFS_SW_CLR = AW'(5);

  function automatic logic [AW-1:0] bank_ofs(input int unsigned bank, input bank_sel_e sel);
    return AW'(bank * BANK_STRIDE) | AW'(sel);
  endfunction

  function automatic logic any_hit(input logic [NSRC-1:0] lvl, input logic [NSRC-1:0] en);
    return (lvl & en) != '0;
  endfunction

  function automatic logic is_view_ofs(input logic [AW-1:0] a);
    return (a == bank_ofs(BANK_IRQ, SEL_STAT)) || (a == bank_ofs(BANK_IRQ, SEL_RAW)) ||
           (a == bank_ofs(BANK_FIQ, SEL_STAT)) || (a == bank_ofs(BANK_FIQ, SEL_RAW));
  endfunction
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_stb,
  input  logic            clr_stb,
  input  logic [NSRC-1:0] data,
  output logic [NSRC-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (set_stb) en_q <= en_q | data;
    else if (clr_stb) en_q <= en_q & ~data;
  end

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((en_q & $past(data)) == $past(data)));
  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((en_q & $past(data)) == '0));
  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(en_q));
endmodule

// File: rtl/intc_soft_src.sv
module intc_soft_src (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  input  logic arm,
  output logic soft_q
);
  logic do_set, do_clr;
  assign do_set = set_stb & arm;
  assign do_clr = clr_stb & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      soft_q <= 1'b0;
    else if (do_set) soft_q <= 1'b1;
    else if (do_clr) soft_q <= 1'b0;
  end

  // R6
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && arm) |=> soft_q);
  // R6
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && arm && !set_stb) |=> !soft_q);
  // R6
  soft_noarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> $stable(soft_q));
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] lvl,
  input  logic [NSRC-1:0] en,
  output logic            req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= any_hit(lvl, en);
  end

  // R7
  out_quiet_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> !req_q);
  // R7
  out_quiet_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !req_q);
endmodule

// File: rtl/intc_dual_lvl.sv
module intc_dual_lvl
  import intc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] rdata,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NSRC-1:0] level;
  logic [NSRC-1:0] en_q [NOUT];
  logic [NOUT-1:0] set_stb, clr_stb, req_q;
  logic            soft_q, sw_set_stb, sw_clr_stb, view_wr;

  assign sw_set_stb = wr_en && (addr == OFS_SW_SET);
  assign sw_clr_stb = wr_en && (addr == OFS_SW_CLR);
  assign view_wr    = wr_en && is_view_ofs(addr);

  intc_soft_src u_soft (
    .clk(clk), .rst_n(rst_n), .set_stb(sw_set_stb), .clr_stb(sw_clr_stb),
    .arm(wdata[0]), .soft_q(soft_q)
  );

  assign level = src_i | {{(NSRC-1){1'b0}}, soft_q};

  for (genvar b = 0; b < NOUT; b++) begin : g_bank
    assign set_stb[b] = wr_en && (addr == bank_ofs(b, SEL_ESET));
    assign clr_stb[b] = wr_en && (addr == bank_ofs(b, SEL_ECLR));

    intc_mask_reg u_mask (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb[b]), .clr_stb(clr_stb[b]),
      .data(wdata), .en_q(en_q[b])
    );

    intc_out_stage u_out (
      .clk(clk), .rst_n(rst_n), .lvl(level), .en(en_q[b]), .req_q(req_q[b])
    );
  end

  assign irq_o = req_q[BANK_IRQ];
  assign fiq_o = req_q[BANK_FIQ];

  always_comb begin
    rdata = '0;
    for (int b = 0; b < NOUT; b++) begin
      if (addr == bank_ofs(b, SEL_STAT)) rdata = level & en_q[b];
      if (addr == bank_ofs(b, SEL_RAW))  rdata = level;
      if (addr == bank_ofs(b, SEL_ESET)) rdata = en_q[b];
    end
    if (addr == OFS_SW_SET) rdata = {{(NSRC-1){1'b0}}, level[0]};
  end

  // R9
  view_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    view_wr |=> ($stable(en_q[BANK_IRQ]) && $stable(en_q[BANK_FIQ]) && $stable(soft_q)));
  // R8
  clr_ofs_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == bank_ofs(BANK_IRQ, SEL_ECLR) || addr == OFS_SW_CLR ||
     addr == bank_ofs(BANK_FIQ, SEL_ECLR)) |-> (rdata == '0));
  // R10
  fiq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((level & en_q[BANK_IRQ]) == '0) |=> !irq_o);
endmodule

// File: tb/sim_intc_dual_lvl.sv
`timescale 1ns/1ps
module sim_intc_dual_lvl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, fiq_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intc_dual_lvl u0 (.clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  typedef struct packed {
    logic [31:0] src;
    logic        we;
    logic [3:0]  waddr;
    logic [31:0] wd;
    logic [3:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_fiq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0010, 1'b1, 4'd2,  32'h0000_0011, 4'd0,  32'h0000_0010, 1'b1, 1'b0}, // R3 R5 R7
    '{32'h0000_0010, 1'b1, 4'd10, 32'h8000_0000, 4'd10, 32'h8000_0000, 1'b1, 1'b0}, // R3
    '{32'h8000_0010, 1'b0, 4'd0,  32'h0000_0000, 4'd9,  32'h8000_0010, 1'b1, 1'b1}, // R2 R10
    '{32'h8000_0010, 1'b1, 4'd3,  32'h0000_0010, 4'd2,  32'h0000_0001, 1'b0, 1'b1}, // R4 R10
    '{32'h8000_0010, 1'b1, 4'd4,  32'h0000_0001, 4'd0,  32'h0000_0001, 1'b1, 1'b1}, // R6 R5
    '{32'h0000_0000, 1'b1, 4'd5,  32'h0000_0002, 4'd4,  32'h0000_0001, 1'b1, 1'b0}, // R6 bit0 zero
    '{32'h0000_0000, 1'b1, 4'd0,  32'hFFFF_FFFF, 4'd2,  32'h0000_0001, 1'b1, 1'b0}, // R9
    '{32'h0000_0000, 1'b1, 4'd5,  32'h0000_0001, 4'd1,  32'h0000_0000, 1'b0, 1'b0}, // R6 clear
    '{32'h0000_0001, 1'b1, 4'd11, 32'hFFFF_FFFF, 4'd4,  32'h0000_0001, 1'b1, 1'b0}, // R4 R6 R2
    '{32'h0000_0001, 1'b1, 4'd10, 32'h0000_0001, 4'd8,  32'h0000_0001, 1'b1, 1'b1}, // R5
    '{32'h0000_0001, 1'b0, 4'd0,  32'h0000_0000, 4'd3,  32'h0000_0000, 1'b1, 1'b1}, // R8
    '{32'h0000_0001, 1'b0, 4'd0,  32'h0000_0000, 4'd11, 32'h0000_0000, 1'b1, 1'b1}, // R8
    '{32'h0000_0001, 1'b0, 4'd0,  32'h0000_0000, 4'd5,  32'h0000_0000, 1'b1, 1'b1}, // R8
    '{32'h0000_0001, 1'b0, 4'd0,  32'h0000_0000, 4'd13, 32'h0000_0000, 1'b1, 1'b1}, // R8
    '{32'h0000_0000, 1'b1, 4'd9,  32'hFFFF_FFFF, 4'd10, 32'h0000_0001, 1'b0, 1'b0}, // R9
    '{32'h0000_0000, 1'b1, 4'd8,  32'h0000_0000, 4'd7,  32'h0000_0000, 1'b0, 1'b0}  // R9 R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irq_o}, 32'h0);
    check("R1 fiq", {31'b0, fiq_o}, 32'h0);
    rd_chk("R1 irq mask", 4'd2, 32'h0);
    rd_chk("R1 fiq mask", 4'd10, 32'h0);
    rd_chk("R1 soft", 4'd4, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      src_i = VECS[i].src; wr_en = VECS[i].we; addr = VECS[i].waddr; wdata = VECS[i].wd;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      @(posedge clk); @(negedge clk);
      check($sformatf("R7 irq vec%0d", i), {31'b0, irq_o}, {31'b0, VECS[i].exp_irq});
      check($sformatf("R7 fiq vec%0d", i), {31'b0, fiq_o}, {31'b0, VECS[i].exp_fiq});
      rd_chk($sformatf("R2-5/R6/R8/R9 read vec%0d", i), VECS[i].raddr, VECS[i].exp_rd);
    end

    // R7 one-clock latency from a source change (irq mask bit0 and fiq mask bit0 are set)
    src_i = 32'h1;
    #1;
    check("R7 irq before edge", {31'b0, irq_o}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 irq after edge", {31'b0, irq_o}, 32'h1);
    check("R7 fiq after edge", {31'b0, fiq_o}, 32'h1);

    // R10 cascade-style source 26 enabled only on the fast line
    src_i = '0; wr_en = 1'b1; addr = 4'd11; wdata = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    addr = 4'd10; wdata = 32'h0400_0000;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; src_i = 32'h0400_0000;
    @(posedge clk); @(negedge clk);
    check("R10 fiq high", {31'b0, fiq_o}, 32'h1);
    check("R10 irq low", {31'b0, irq_o}, 32'h0);
    rd_chk("R5 fiq status", 4'd8, 32'h0400_0000);
    rd_chk("R5 irq status", 4'd0, 32'h0);

    // R1 reset in mid-run
    rst_n = 1'b0;
    #1;
    check("R1 fiq cleared", {31'b0, fiq_o}, 32'h0);
    rd_chk("R1 irq mask cleared", 4'd2, 32'h0);
    rd_chk("R1 fiq mask cleared", 4'd10, 32'h0);
    rst_n = 1'b1;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule